// File: doc/BRIEF.md
# Clock Multiplier Configuration Register with Lock Timer

This block holds the programming word for one clock multiplier. The word has a divider setting, a multiplier setting and a lock-wait count. A simple register bus writes the word with a one-cycle strobe and a 32-bit data word. The stored word can be read back at any time. The fields drive the multiplier control outputs directly. The divider setting is also decoded into one of three modes: output held low, bypass, or divide.

Each accepted write starts a lock-wait timer. The timer advances on a slow-clock enable pulse, which arrives in the bus clock domain. The lock flag rises once eight times the count field has elapsed, and a write always restarts the wait. An input can freeze the register against writes. A write with the must-be-one bit clear is refused and reported. A multiplier value above the legal range is stored as written and raises a status bit.

Top module: `pll_cfg_reg`

## Requirements
- R1: After reset every field is 0, `mul_on` is 0, `lock` is 0, `bad_prog` is 0, `div_mode` is 0, and `rdata` reads 32'h2000_0000.
- R2: An accepted write stores divider from `wdata[7:0]`, lock count from `wdata[13:8]` and multiplier from `wdata[26:16]`, visible on the next cycle. `rdata` returns these fields at the same positions, with bit 29 as 1 and every other bit as 0.
- R3: A write with `wdata[29]` clear and `wp_en` low changes no field and no timer state. `bad_prog` is 1 for exactly the cycle after that strobe.
- R4: While `wp_en` is 1 a write strobe has no effect on any field, on `lock` or on `bad_prog`.
- R5: An accepted write clears `lock` on the next cycle. With count field c, `lock` rises on the (8*c+1)-th `slow_tick` pulse after the write, and it stays high until the next accepted write.
- R6: With count field 0, `lock` rises on the first `slow_tick` pulse after the write.
- R7: A multiplier value of 0 drives `mul_on` to 0. While the multiplier is disabled, `lock` stays 0 and the timer does not advance. Any nonzero value drives `mul_on` to 1.
- R8: `mul_range_err` is 1 exactly when the stored multiplier exceeds 62.
- R9: `div_mode` is 0 (output held low) for divider 0, 1 (bypass) for divider 1, and 2 (divide) for divider 2 to 255.
- R10: When an accepted write and a `slow_tick` pulse fall in the same cycle, the write wins and the pulse is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slow_tick | input | 1 | One-cycle pulse per slow-clock edge |
| wr_en | input | 1 | Write strobe |
| wdata | input | 32 | Write data word |
| wp_en | input | 1 | Write protection; blocks all writes when 1 |
| rdata | output | 32 | Read-back word |
| div_val | output | 8 | Stored divider setting |
| cnt_val | output | 6 | Stored lock count |
| mul_val | output | 11 | Stored multiplier setting |
| mul_on | output | 1 | Multiplier enable |
| div_mode | output | 2 | 0 = held low, 1 = bypass, 2 = divide |
| lock | output | 1 | Lock flag |
| bad_prog | output | 1 | Pulse after a write with bit 29 clear |
| mul_range_err | output | 1 | Stored multiplier above 62 |

## Verification
Four properties are checked on every cycle:
- the lock flag is never high while the multiplier is disabled;
- a protected or malformed write leaves the read word unchanged;
- an accepted write drops the lock flag;
- the lock flag only rises right after a slow tick.

The exact length of the lock wait needs directed scenarios checked against the bench's reference model. So do the count-zero case, a write that collides with a tick, the freeze while disabled, the divider mode decode and the range flag.

// File: rtl/pll_cfg_reg.sv
module pll_cfg_reg #(
  parameter int DIV_W   = 8,
  parameter int CNT_W   = 6,
  parameter int MUL_W   = 11,
  parameter int MUL_MAX = 62
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             slow_tick,
  input  logic             wr_en,
  input  logic [31:0]      wdata,
  input  logic             wp_en,
  output logic [31:0]      rdata,
  output logic [DIV_W-1:0] div_val,
  output logic [CNT_W-1:0] cnt_val,
  output logic [MUL_W-1:0] mul_val,
  output logic             mul_on,
  output logic [1:0]       div_mode,
  output logic             lock,
  output logic             bad_prog,
  output logic             mul_range_err
);
  localparam int CNT_LSB = 8;
  localparam int MUL_LSB = 16;
  localparam int ONE_BIT = 29;
  localparam int TMR_W   = CNT_W + 3;

  logic [TMR_W-1:0] remain;

  wire wr_ok  = wr_en && !wp_en && wdata[ONE_BIT];
  wire wr_bad = wr_en && !wp_en && !wdata[ONE_BIT];
  wire unused_wbits = ^{wdata[31:30], wdata[28:27], wdata[15:14]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_val  <= '0;
      cnt_val  <= '0;
      mul_val  <= '0;
      remain   <= '0;
      lock     <= 1'b0;
      bad_prog <= 1'b0;
    end else begin
      bad_prog <= wr_bad;
      if (wr_ok) begin
        div_val <= wdata[DIV_W-1:0];
        cnt_val <= wdata[CNT_LSB +: CNT_W];
        mul_val <= wdata[MUL_LSB +: MUL_W];
        remain  <= {wdata[CNT_LSB +: CNT_W], 3'b000};
        lock    <= 1'b0;
      end else if (slow_tick && mul_on && !lock) begin
        if (remain == '0) lock <= 1'b1;
        else              remain <= remain - 1'b1;
      end
    end
  end

  assign mul_on        = (mul_val != '0);
  assign mul_range_err = (mul_val > MUL_W'(MUL_MAX));
  assign div_mode      = (div_val == '0) ? 2'd0 : (div_val == DIV_W'(1)) ? 2'd1 : 2'd2;

  always_comb begin
    rdata = '0;
    rdata[DIV_W-1:0]          = div_val;
    rdata[CNT_LSB +: CNT_W]   = cnt_val;
    rdata[MUL_LSB +: MUL_W]   = mul_val;
    rdata[ONE_BIT]            = 1'b1;
  end

  AST_LOCK_NEEDS_MUL: assert property (@(posedge clk) disable iff (!rst_n)
    lock |-> mul_on);                                          // R7
  AST_BAD_WRITE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wp_en && !wdata[ONE_BIT]) |=> $stable(rdata));  // R3
  AST_PROTECT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wp_en) |=> $stable(rdata));                      // R4
  AST_WRITE_DROPS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wp_en && wdata[ONE_BIT]) |=> !lock);            // R5
  AST_LOCK_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock) |-> $past(slow_tick));                         // R6
endmodule

// File: tb/pll_cfg_reg_test.sv
`timescale 1ns/1ps
module pll_cfg_reg_test;
  logic clk = 1'b0, rst_n = 1'b0, slow_tick = 1'b0, wr_en = 1'b0, wp_en = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [7:0]  div_val;
  logic [5:0]  cnt_val;
  logic [10:0] mul_val;
  logic        mul_on, lock, bad_prog, mul_range_err;
  logic [1:0]  div_mode;

  int checks = 0, errors = 0, cycles = 0;
  bit done = 0;
  int m_div = 0, m_cnt = 0, m_mul = 0, m_rem = 0, m_lock = 0, m_bad = 0;

  pll_cfg_reg uut (.clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .wr_en(wr_en),
    .wdata(wdata), .wp_en(wp_en), .rdata(rdata), .div_val(div_val), .cnt_val(cnt_val),
    .mul_val(mul_val), .mul_on(mul_on), .div_mode(div_mode), .lock(lock),
    .bad_prog(bad_prog), .mul_range_err(mul_range_err));

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // reference model
  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      m_div = 0; m_cnt = 0; m_mul = 0; m_rem = 0; m_lock = 0; m_bad = 0;
    end else begin
      m_bad = (wr_en && !wp_en && !wdata[29]) ? 1 : 0;
      if (wr_en && !wp_en && wdata[29]) begin
        m_div = int'(wdata[7:0]); m_cnt = int'(wdata[13:8]); m_mul = int'(wdata[26:16]);
        m_rem = m_cnt * 8; m_lock = 0;
      end else if (slow_tick && m_mul != 0 && m_lock == 0) begin
        if (m_rem == 0) m_lock = 1; else m_rem = m_rem - 1;
      end
    end
  end

  always @(negedge clk) if (rst_n) begin
    longint exp_rd;
    int exp_mode;
    exp_rd = (longint'(1) << 29) | (longint'(m_mul) << 16) | (longint'(m_cnt) << 8) | m_div;
    exp_mode = (m_div == 0) ? 0 : (m_div == 1) ? 1 : 2;
    chk(rdata == exp_rd[31:0], "R2 rdata", rdata, exp_rd);
    chk(lock == m_lock[0], "R5 lock", lock, m_lock);
    chk(bad_prog == m_bad[0], "R3 bad_prog", bad_prog, m_bad);
    chk(mul_on == (m_mul != 0), "R7 mul_on", mul_on, m_mul != 0);
    chk(mul_range_err == (m_mul > 62), "R8 range", mul_range_err, m_mul > 62);
    chk(div_mode == exp_mode[1:0], "R9 div_mode", div_mode, exp_mode);
  end

  always @(posedge clk) if (cycles > 100000 && !done) begin
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  function automatic logic [31:0] word(input int mul, input int cnt, input int dv, input bit one);
    return {2'b00, one, 2'b00, mul[10:0], 2'b00, cnt[5:0], dv[7:0]};
  endfunction

  task automatic wr(input logic [31:0] d, input bit tick = 0);
    @(negedge clk); wr_en = 1; wdata = d; slow_tick = tick;
    @(negedge clk); wr_en = 0; slow_tick = 0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); slow_tick = 1;
      @(negedge clk); slow_tick = 0;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(rdata == 32'h2000_0000, "R1 rdata", rdata, 32'h2000_0000);
    chk(!lock && !mul_on && !bad_prog && div_mode == 0, "R1 flags", {lock, mul_on, bad_prog}, 0);
    // R2, R5: count 2 -> lock on 17th tick
    wr(word(10, 2, 5, 1));
    chk(div_val == 5 && cnt_val == 2 && mul_val == 10, "R2 fields", rdata, word(10, 2, 5, 1));
    ticks(16);
    chk(lock == 0, "R5 early", lock, 0);
    ticks(1);
    chk(lock == 1, "R5 set", lock, 1);
    // R5 restart by new write
    wr(word(3, 1, 2, 1));
    chk(lock == 0, "R5 cleared", lock, 0);
    ticks(8);
    chk(lock == 0, "R5 restart early", lock, 0);
    ticks(1);
    chk(lock == 1, "R5 restart set", lock, 1);
    // R3 bad write
    @(negedge clk); wr_en = 1; wdata = word(40, 3, 9, 0);
    @(negedge clk); wr_en = 0;
    chk(bad_prog == 1 && mul_val == 3 && lock == 1, "R3 refused", bad_prog, 1);
    @(negedge clk);
    chk(bad_prog == 0, "R3 one cycle", bad_prog, 0);
    // R4 write protect
    wp_en = 1;
    wr(word(7, 0, 1, 1));
    wr(word(7, 0, 1, 0));
    chk(mul_val == 3 && lock == 1 && bad_prog == 0, "R4 protected", mul_val, 3);
    wp_en = 0;
    // R6 count zero
    wr(word(4, 0, 1, 1));
    ticks(1);
    chk(lock == 1, "R6 first tick", lock, 1);
    // R10 write with coincident tick
    wr(word(4, 0, 0, 1), 1);
    chk(lock == 0, "R10 tick ignored", lock, 0);
    ticks(1);
    chk(lock == 1, "R10 next tick", lock, 1);
    // R7 disabled multiplier freezes timer
    wr(word(0, 0, 255, 1));
    ticks(5);
    chk(lock == 0 && mul_on == 0, "R7 disabled", lock, 0);
    wr(word(1, 1, 2, 1));
    ticks(9);
    chk(lock == 1, "R7 reenabled", lock, 1);
    // R8 range
    wr(word(63, 0, 0, 1));
    chk(mul_range_err == 1, "R8 63", mul_range_err, 1);
    wr(word(62, 0, 0, 1));
    chk(mul_range_err == 0, "R8 62", mul_range_err, 0);
    wr(word(2047, 0, 1, 1));
    chk(mul_range_err == 1 && mul_val == 2047, "R8 max", mul_val, 2047);
    // R9 modes
    wr(word(5, 0, 0, 1));   chk(div_mode == 0, "R9 zero", div_mode, 0);
    wr(word(5, 0, 1, 1));   chk(div_mode == 1, "R9 bypass", div_mode, 1);
    wr(word(5, 0, 255, 1)); chk(div_mode == 2, "R9 divide", div_mode, 2);
    ticks(2);
    finish_run();
  end
endmodule